// File: doc/BRIEF.md
# Processor Status and Mode Register

This block holds the eight condition and mode flags of an 8/16-bit processor core, together with a hidden emulation bit. The flags are carry, zero, interrupt disable, decimal, index width, accumulator width, overflow and negative. Each cycle it can take two kinds of update at once.

The first is a masked flag update from the ALU. The second is one explicit command. The command can be:
- a single-flag set or clear;
- a masked clear or set driven by an 8-bit immediate;
- a full load of a byte pulled from the stack;
- a swap of carry with the emulation bit.

The block drives the accumulator-width and index-width bits to the rest of the core. A width bit at 1 means 8-bit and at 0 means 16-bit.

While the emulation bit is 1, both width bits are held at 1. In that mode the index-width position acts as the break flag. The block also raises a one-cycle pulse whenever the index width goes from 16-bit to 8-bit. The register file uses that pulse to zero the upper bytes of the two index registers. Reset leaves the block in emulation mode, with interrupts disabled and decimal mode off.

Top module: `status_reg_core`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after release, `status_q` is 8'h34, `emu_q` is 1 and `idx_hi_clear` is 0. The value 8'h34 means interrupt disable and both width bits set; every other bit is clear.
- R2: The flag positions in `status_q` are fixed and other logic decodes them:
  - bit 0 carry, bit 1 zero, bit 2 interrupt disable, bit 3 decimal;
  - bit 4 index width, bit 5 accumulator width, bit 6 overflow, bit 7 negative.
  `acc_narrow` always equals bit 5 and `idx_narrow` always equals bit 4.
- R3: For each bit whose `alu_we` bit is 1, the flag takes the matching `alu_flags` bit at the next clock edge. Bits whose `alu_we` bit is 0 keep their value.
- R4: `cmd_op` values 1 to 7 each act on one flag at the next edge:
  - 1 clears carry and 2 sets carry;
  - 3 clears interrupt disable and 4 sets it;
  - 5 clears decimal and 6 sets it;
  - 7 clears overflow.
  No command sets overflow.
- R5: `cmd_op` 8 clears every flag whose bit in `cmd_imm` is 1. Flags whose `cmd_imm` bit is 0 are left as they are.
- R6: `cmd_op` 9 sets every flag whose bit in `cmd_imm` is 1. Flags whose `cmd_imm` bit is 0 are left as they are.
- R7: `cmd_op` 10 replaces all eight flags with `cmd_imm` in one step.
- R8: `cmd_op` 11 exchanges carry and the emulation bit in one step. The emulation bit takes the carry value from before the edge, and carry takes the old emulation bit.
- R9: Whenever `emu_q` is 1, status bits 5 and 4 are 1. This holds even against a clear, a load or an ALU write aimed at them, and also on the edge that enters emulation mode.
- R10: `idx_hi_clear` is 1 for exactly the one cycle in which bit 4 of `status_q` first reads 1 after having read 0. It is 0 at all other times.
- R11: When an ALU write and a command fall in the same cycle, the command decides every bit it writes and the ALU write decides the rest. A load (`cmd_op` 10) overrides the whole ALU write. A swap overrides only the ALU's carry.
- R12: `cmd_op` 0 and the unused values 12 to 15 leave every flag and the emulation bit unchanged, whatever `cmd_imm` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_op | input | 4 | Explicit status command code (see R4 to R8, R12) |
| cmd_imm | input | 8 | Immediate mask for the masked commands, or the pulled byte for a load |
| alu_we | input | 8 | Per-flag write enable from the ALU |
| alu_flags | input | 8 | Flag values from the ALU, in status bit order |
| status_q | output | 8 | Current status flags |
| emu_q | output | 1 | Hidden emulation bit |
| acc_narrow | output | 1 | Accumulator width: 1 = 8-bit, 0 = 16-bit |
| idx_narrow | output | 1 | Index width: 1 = 8-bit, 0 = 16-bit |
| idx_hi_clear | output | 1 | One-cycle request to zero the upper bytes of the index registers |

## Verification
The two functions that can land in the same cycle are the ALU's masked flag write and an explicit command. The harder case is a command that touches the same bit as the ALU, for example:
- a carry set against an ALU carry clear;
- a masked clear overlapping the ALU mask;
- a swap together with an ALU carry write;
- a load against an all-ones ALU mask.

The bench provokes these deliberately, then runs a long stretch of random commands with random ALU masks. A behavioural model predicts every bit, the emulation bit and the width pulse, and the bench compares them with the outputs after every edge. Entering emulation through a swap while the index width is 16-bit is also staged. That case lets the width forcing and the shrink pulse be judged on the same edge as the swap.

// File: rtl/stat_pkg.sv
package stat_pkg;
  localparam int FLAG_W = 8;
  localparam int OP_W   = 4;

  localparam int B_C = 0;
  localparam int B_Z = 1;
  localparam int B_I = 2;
  localparam int B_D = 3;
  localparam int B_X = 4;
  localparam int B_M = 5;
  localparam int B_V = 6;
  localparam int B_N = 7;

  typedef logic [FLAG_W-1:0] flags_t;

  typedef enum logic [OP_W-1:0] {
    CMD_NOP      = 4'd0,
    CMD_CLR_C    = 4'd1,
    CMD_SET_C    = 4'd2,
    CMD_CLR_I    = 4'd3,
    CMD_SET_I    = 4'd4,
    CMD_CLR_D    = 4'd5,
    CMD_SET_D    = 4'd6,
    CMD_CLR_V    = 4'd7,
    CMD_MASK_CLR = 4'd8,
    CMD_MASK_SET = 4'd9,
    CMD_LOAD     = 4'd10,
    CMD_SWAP     = 4'd11
  } cmd_e;

  localparam flags_t RESET_FLAGS = flags_t'((1 << B_I) | (1 << B_X) | (1 << B_M));
endpackage

// File: rtl/stat_cmd_decode.sv
module stat_cmd_decode
  import stat_pkg::*;
(
  input  logic [OP_W-1:0]   op,
  input  logic [FLAG_W-1:0] imm,
  output logic [FLAG_W-1:0] set_m,
  output logic [FLAG_W-1:0] clr_m,
  output logic              load_en,
  output logic              swap_en
);
  always_comb begin
    set_m   = '0;
    clr_m   = '0;
    load_en = 1'b0;
    swap_en = 1'b0;
    case (cmd_e'(op))
      CMD_CLR_C:    clr_m[B_C] = 1'b1;
      CMD_SET_C:    set_m[B_C] = 1'b1;
      CMD_CLR_I:    clr_m[B_I] = 1'b1;
      CMD_SET_I:    set_m[B_I] = 1'b1;
      CMD_CLR_D:    clr_m[B_D] = 1'b1;
      CMD_SET_D:    set_m[B_D] = 1'b1;
      CMD_CLR_V:    clr_m[B_V] = 1'b1;
      CMD_MASK_CLR: clr_m      = imm;
      CMD_MASK_SET: set_m      = imm;
      CMD_LOAD:     load_en    = 1'b1;
      CMD_SWAP:     swap_en    = 1'b1;
      default:      ;
    endcase
  end
endmodule

// File: rtl/stat_next_calc.sv
module stat_next_calc
  import stat_pkg::*;
(
  input  logic [FLAG_W-1:0] cur,
  input  logic              cur_emu,
  input  logic [FLAG_W-1:0] alu_we,
  input  logic [FLAG_W-1:0] alu_flags,
  input  logic [FLAG_W-1:0] load_val,
  input  logic              load_en,
  input  logic              swap_en,
  input  logic [FLAG_W-1:0] set_m,
  input  logic [FLAG_W-1:0] clr_m,
  output logic [FLAG_W-1:0] nxt,
  output logic              nxt_emu
);
  logic [FLAG_W-1:0] merged;
  logic [FLAG_W-1:0] masked;

  assign nxt_emu = swap_en ? cur[B_C] : cur_emu;

  for (genvar b = 0; b < FLAG_W; b++) begin : g_bit
    assign merged[b] = load_en ? load_val[b] : (alu_we[b] ? alu_flags[b] : cur[b]);
    assign masked[b] = (merged[b] & ~clr_m[b]) | set_m[b];
    if (b == B_C) begin : g_carry
      assign nxt[b] = swap_en ? cur_emu : masked[b];
    end else if (b == B_X || b == B_M) begin : g_width
      assign nxt[b] = masked[b] | nxt_emu;
    end else begin : g_plain
      assign nxt[b] = masked[b];
    end
  end
endmodule

// File: rtl/stat_width_ctrl.sv
module stat_width_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic cur_x,
  input  logic nxt_x,
  output logic shrink_pulse
);
  logic pulse_d;

  assign pulse_d = ~cur_x & nxt_x;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shrink_pulse <= 1'b0;
    else        shrink_pulse <= pulse_d;
  end

  // R10
  pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shrink_pulse |-> cur_x && !$past(cur_x));

  // R10
  pulse_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cur_x) |-> shrink_pulse);
endmodule

// File: rtl/status_reg_core.sv
module status_reg_core
  import stat_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [OP_W-1:0]       cmd_op,
  input  logic [FLAG_W-1:0]     cmd_imm,
  input  logic [FLAG_W-1:0]     alu_we,
  input  logic [FLAG_W-1:0]     alu_flags,
  output logic [FLAG_W-1:0]     status_q,
  output logic                  emu_q,
  output logic                  acc_narrow,
  output logic                  idx_narrow,
  output logic                  idx_hi_clear
);
  logic [FLAG_W-1:0] set_m, clr_m, flags_d;
  logic              load_en, swap_en, emu_d;

  stat_cmd_decode u_dec (
    .op      (cmd_op),
    .imm     (cmd_imm),
    .set_m   (set_m),
    .clr_m   (clr_m),
    .load_en (load_en),
    .swap_en (swap_en)
  );

  stat_next_calc u_calc (
    .cur       (status_q),
    .cur_emu   (emu_q),
    .alu_we    (alu_we),
    .alu_flags (alu_flags),
    .load_val  (cmd_imm),
    .load_en   (load_en),
    .swap_en   (swap_en),
    .set_m     (set_m),
    .clr_m     (clr_m),
    .nxt       (flags_d),
    .nxt_emu   (emu_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= RESET_FLAGS;
      emu_q    <= 1'b1;
    end else begin
      status_q <= flags_d;
      emu_q    <= emu_d;
    end
  end

  stat_width_ctrl u_width (
    .clk          (clk),
    .rst_n        (rst_n),
    .cur_x        (status_q[B_X]),
    .nxt_x        (flags_d[B_X]),
    .shrink_pulse (idx_hi_clear)
  );

  assign acc_narrow = status_q[B_M];
  assign idx_narrow = status_q[B_X];

  // R9
  emu_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    emu_q |-> (status_q[B_M] && status_q[B_X]));

  // R8
  swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == CMD_SWAP) |=> (emu_q == $past(status_q[B_C])) && (status_q[B_C] == $past(emu_q)));

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_op == CMD_NOP || cmd_op > CMD_SWAP) && alu_we == '0) |=> $stable(status_q) && $stable(emu_q));

  // R5
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == CMD_MASK_CLR) |=>
      ((status_q & $past(cmd_imm) & ~{2'b00, emu_q, emu_q, 4'b0000}) == '0));

  // R7
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == CMD_LOAD && !emu_q) |=> (status_q == $past(cmd_imm)));
endmodule

// File: tb/tb_status_reg_core.sv
`timescale 1ns/1ps
module tb_status_reg_core;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] cmd_op;
  logic [7:0] cmd_imm, alu_we, alu_flags;
  logic [7:0] status_q;
  logic       emu_q, acc_narrow, idx_narrow, idx_hi_clear;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [7:0] m_f;
  logic       m_e;
  logic       m_p;

  always #5 clk = ~clk;

  status_reg_core dut (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_imm(cmd_imm),
    .alu_we(alu_we), .alu_flags(alu_flags), .status_q(status_q),
    .emu_q(emu_q), .acc_narrow(acc_narrow), .idx_narrow(idx_narrow),
    .idx_hi_clear(idx_hi_clear)
  );

  task automatic check(string tag);
    checks++;
    if (status_q !== m_f || emu_q !== m_e || acc_narrow !== m_f[5] ||
        idx_narrow !== m_f[4] || idx_hi_clear !== m_p) begin
      errors++;
      $display("FAIL %s: got status=%h emu=%b acc=%b idx=%b pulse=%b, expected status=%h emu=%b acc=%b idx=%b pulse=%b",
               tag, status_q, emu_q, acc_narrow, idx_narrow, idx_hi_clear,
               m_f, m_e, m_f[5], m_f[4], m_p);
    end
  endtask

  task automatic step(input logic [3:0] op, input logic [7:0] imm,
                      input logic [7:0] we, input logic [7:0] af, input string tag);
    logic [7:0] f;
    logic       e;
    @(negedge clk);
    cmd_op = op; cmd_imm = imm; alu_we = we; alu_flags = af;
    f = (m_f & ~we) | (af & we);
    e = m_e;
    case (op)
      4'd1:  f[0] = 1'b0;
      4'd2:  f[0] = 1'b1;
      4'd3:  f[2] = 1'b0;
      4'd4:  f[2] = 1'b1;
      4'd5:  f[3] = 1'b0;
      4'd6:  f[3] = 1'b1;
      4'd7:  f[6] = 1'b0;
      4'd8:  f = f & ~imm;
      4'd9:  f = f | imm;
      4'd10: f = imm;
      4'd11: begin f[0] = m_e; e = m_f[0]; end
      default: ;
    endcase
    if (e) f[5:4] = 2'b11;
    @(posedge clk);
    m_p = !m_f[4] && f[4];
    m_f = f;
    m_e = e;
    #1;
    check(tag);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cmd_op = 4'd0; cmd_imm = 8'h00; alu_we = 8'h00; alu_flags = 8'h00;
    m_f = 8'h34; m_e = 1'b1; m_p = 1'b0;
    repeat (3) @(posedge clk);
    #1 check("R1");
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk);
    #1 check("R1");

    // leave emulation: carry 0 -> emu 0, carry 1
    step(4'd11, 8'h00, 8'h00, 8'h00, "R8");
    step(4'd8,  8'h30, 8'h00, 8'h00, "R5");
    step(4'd0,  8'h00, 8'hC3, 8'h81, "R3");
    step(4'd0,  8'h00, 8'h42, 8'h42, "R3");
    step(4'd0,  8'h00, 8'hFF, 8'h00, "R2");
    step(4'd2,  8'hFF, 8'h00, 8'h00, "R4");
    step(4'd1,  8'h00, 8'h00, 8'h00, "R4");
    step(4'd4,  8'h00, 8'h00, 8'h00, "R4");
    step(4'd3,  8'h00, 8'h00, 8'h00, "R4");
    step(4'd6,  8'h00, 8'h00, 8'h00, "R4");
    step(4'd5,  8'h00, 8'h00, 8'h00, "R4");
    step(4'd9,  8'h40, 8'h00, 8'h00, "R6");
    step(4'd7,  8'h00, 8'h00, 8'h00, "R4");
    step(4'd9,  8'h10, 8'h00, 8'h00, "R10");
    step(4'd0,  8'h00, 8'h00, 8'h00, "R10");
    step(4'd9,  8'h20, 8'h00, 8'h00, "R6");
    step(4'd8,  8'h10, 8'h00, 8'h00, "R5");
    step(4'd10, 8'h00, 8'h00, 8'h00, "R7");
    step(4'd10, 8'hFF, 8'h00, 8'h00, "R7");
    step(4'd10, 8'h5A, 8'h00, 8'h00, "R7");
    for (int op = 12; op < 16; op++) step(4'(op), 8'hFF, 8'h00, 8'h00, "R12");
    step(4'd0,  8'hA5, 8'h00, 8'h00, "R12");
    // same-cycle command and ALU write
    step(4'd2,  8'h00, 8'h01, 8'h00, "R11");
    step(4'd8,  8'h01, 8'h81, 8'h81, "R11");
    step(4'd10, 8'h0F, 8'hFF, 8'hF0, "R11");
    step(4'd9,  8'h80, 8'hFF, 8'h00, "R11");
    step(4'd8,  8'h10, 8'h00, 8'h00, "R10");
    // enter emulation with index 16-bit via swap, ALU fighting carry
    step(4'd2,  8'h00, 8'h00, 8'h00, "R4");
    step(4'd11, 8'h00, 8'h31, 8'h00, "R9");
    step(4'd8,  8'h30, 8'h00, 8'h00, "R9");
    step(4'd10, 8'h00, 8'h00, 8'h00, "R9");
    step(4'd0,  8'h00, 8'h30, 8'h00, "R9");
    step(4'd11, 8'h00, 8'h00, 8'h00, "R8");
    for (int i = 0; i < 400; i++)
      step(4'($urandom_range(0, 15)), 8'($urandom), 8'($urandom), 8'($urandom), "R11");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule